// File: doc/BRIEF.md
# Three-Slot Instruction Decode Steering

This block sits between an instruction queue and a set of three decoders of unequal ability. In each cycle it looks at up to three pending instructions, oldest first, and decides how many of them can be decoded together. Each pending instruction carries a small kind code that tells how many micro-ops it expands to, or that it is microcoded. Slot 0 is the capable decoder: it takes any instruction of one to four micro-ops in a single cycle, and it is the only slot that takes a microcoded instruction. Slots 1 and 2 take single-micro-op instructions only, and they fill only behind a slot 0 instruction in the same cycle. The best case is therefore a group of one instruction of up to four micro-ops followed by two single-micro-op instructions.

The queue offers instructions with a per-lane valid vector and sees a ready flag and a count of how many lanes were taken in that cycle. That count is returned at once, so the queue can advance by exactly that many entries. The group that was accepted appears one cycle later on registered outputs: a valid flag, a fill mask per slot, the micro-op count each slot received, and a flag that marks a microcoded instruction in slot 0. A microcoded instruction brings a cycle count. While it expands, the block holds slot 0 and the whole group, and ready stays low.

Top module: `decode_steer`

## Requirements
- R1: While rst_n is low, in_ready is 0. After reset, out_valid is 0, out_fill is all zeros and out_mc is 0 until the first group is accepted.
- R2: The kind code of each lane sets its micro-op count as follows: 0 register-register = 1, 1 load = 1, 2 store = 2, 3 read-modify = 2, 4 register-memory = 3, 5 read-modify-write = 4. Codes 6 and 7 mark a microcoded instruction. Lane i uses bits [3i+2:3i] of in_kind.
- R3: When in_ready is 1 and lane 0 is valid with a non-microcoded kind, lane 0 is always taken into slot 0, whatever its micro-op count from 1 to 4. in_take is then at least 1.
- R4: Lane i (i ≥ 1) goes into slot i only if it is valid and its kind is single-micro-op (code 0 or 1). Any other lane ends the group, and in_take counts only the lanes taken.
- R5: Lanes are taken strictly in order. Once a lane is refused, no later lane is taken in that cycle, even a single-micro-op one.
- R6: Slots 1 and 2 are never filled unless slot 0 is filled in the same group. With lane 0 invalid, in_take is 0 whatever the other lanes hold.
- R7: A microcoded instruction is taken only from lane 0 and is taken alone (in_take = 1). Its group shows out_fill = 001, out_mc = 1 and a slot 0 micro-op count of 0.
- R8: After a microcoded instruction with cycle count N is accepted, in_ready stays 0 for max(N,2)−1 cycles and nothing is taken. It then returns to 1.
- R9: The out_* signals show the group accepted at the previous clock edge. out_uops field i (bits [3i+2:3i]) holds slot i's micro-op count, or 0 when the slot is empty. A cycle with no acceptance gives out_valid = 0 in the next cycle.
- R10: A microcoded instruction in lane 1 or 2 ends the group and is not taken in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | NUM_SLOTS | Lane i holds a pending instruction (lane 0 oldest) |
| in_kind | input | 3*NUM_SLOTS | Kind code per lane |
| in_mc_cycles | input | CNT_W | Expansion cycle count of a microcoded instruction in lane 0 |
| in_ready | output | 1 | Block can accept a group this cycle |
| in_take | output | TAKE_W | Number of lanes accepted this cycle |
| out_valid | output | 1 | A group was accepted at the last edge |
| out_fill | output | NUM_SLOTS | Slot i received an instruction |
| out_uops | output | 3*NUM_SLOTS | Micro-op count per slot |
| out_mc | output | 1 | Slot 0 holds a microcoded instruction |

## Verification
The grouping logic is driven with full best-case groups (two- and four-micro-op leaders followed by two single-micro-op lanes). These show that slot 0 takes every legal count and that the simple slots fill behind it. Groups with a multi-micro-op instruction in lane 1 or 2 separate a correct stop in program order from a design that skips ahead to a later simple lane. A group with lane 0 invalid separates the rule that slot 0 must fill first from simple per-lane filling. Microcoded instructions with a long count, with a count below the minimum, and in a trailing lane check how long ready stays low, that the instruction is taken alone, and that a trailing microcoded lane is refused.

// File: rtl/ds_pkg.sv
package ds_pkg;

   typedef enum logic [2:0] {
      K_REGREG = 3'd0,
      K_LOAD   = 3'd1,
      K_STORE  = 3'd2,
      K_RDMOD  = 3'd3,
      K_REGMEM = 3'd4,
      K_RMW    = 3'd5,
      K_MC_A   = 3'd6,
      K_MC_B   = 3'd7
   } kind_t;

   localparam int KIND_W = 3;
   localparam int UOP_W  = 3;

   function automatic logic [UOP_W-1:0] uop_count(input kind_t k);
      case (k)
         K_REGREG, K_LOAD: uop_count = 3'd1;
         K_STORE, K_RDMOD: uop_count = 3'd2;
         K_REGMEM:         uop_count = 3'd3;
         K_RMW:            uop_count = 3'd4;
         default:          uop_count = 3'd0;
      endcase
   endfunction

endpackage

// File: rtl/ds_lane_class.sv
module ds_lane_class
   import ds_pkg::*;
(
   input  logic [KIND_W-1:0] kind,
   output logic [UOP_W-1:0]  uops,
   output logic              single,
   output logic              mcode
);

   kind_t k;

   always_comb begin
      k      = kind_t'(kind);
      uops   = uop_count(k);
      mcode  = (k == K_MC_A) || (k == K_MC_B);
      single = (uops == 3'd1);
   end

endmodule

// File: rtl/ds_group_pick.sv
module ds_group_pick #(
   parameter int NUM_SLOTS = 3,
   localparam int TAKE_W = $clog2(NUM_SLOTS + 1)
) (
   input  logic                 ready,
   input  logic [NUM_SLOTS-1:0] valid,
   input  logic [NUM_SLOTS-1:0] single,
   input  logic [NUM_SLOTS-1:0] mcode,
   output logic [NUM_SLOTS-1:0] acc,
   output logic [TAKE_W-1:0]    take
);

   assign acc[0] = ready & valid[0];

   genvar gi;
   generate
      for (gi = 1; gi < NUM_SLOTS; gi++) begin : g_tail
         assign acc[gi] = acc[gi-1] & valid[gi] & single[gi] & ~mcode[gi] & ~mcode[0];
      end
   endgenerate

   always_comb begin
      take = '0;
      for (int i = 0; i < NUM_SLOTS; i++) begin
         take = take + TAKE_W'(acc[i]);
      end
   end

endmodule

// File: rtl/ds_mc_hold.sv
module ds_mc_hold #(
   parameter int CNT_W = 6
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] cycles,
   output logic             ready
);

   logic [CNT_W-1:0] remain;
   logic [CNT_W-1:0] first;

   always_comb begin
      if (cycles < CNT_W'(2)) first = CNT_W'(1);
      else                    first = cycles - CNT_W'(1);
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                remain <= '0;
      else if (load)             remain <= first;
      else if (remain != '0)     remain <= remain - CNT_W'(1);
   end

   assign ready = rst_n && (remain == '0);

   assert_mc_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
      load |=> !ready);

endmodule

// File: rtl/decode_steer.sv
module decode_steer
   import ds_pkg::*;
#(
   parameter int NUM_SLOTS = 3,
   parameter int CNT_W     = 6,
   localparam int TAKE_W   = $clog2(NUM_SLOTS + 1)
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic [NUM_SLOTS-1:0]       in_valid,
   input  logic [KIND_W*NUM_SLOTS-1:0] in_kind,
   input  logic [CNT_W-1:0]           in_mc_cycles,
   output logic                       in_ready,
   output logic [TAKE_W-1:0]          in_take,
   output logic                       out_valid,
   output logic [NUM_SLOTS-1:0]       out_fill,
   output logic [UOP_W*NUM_SLOTS-1:0] out_uops,
   output logic                       out_mc
);

   generate
      if (NUM_SLOTS < 2 || NUM_SLOTS > 8) begin : g_bad_slots
         $error("decode_steer: NUM_SLOTS must be 2..8");
      end
      if (CNT_W < 2) begin : g_bad_cnt
         $error("decode_steer: CNT_W must be at least 2");
      end
   endgenerate

   logic [NUM_SLOTS-1:0]       single;
   logic [NUM_SLOTS-1:0]       mcode;
   logic [NUM_SLOTS-1:0]       acc;
   logic [UOP_W*NUM_SLOTS-1:0] uops;
   logic [UOP_W*NUM_SLOTS-1:0] uops_next;

   genvar gi;
   generate
      for (gi = 0; gi < NUM_SLOTS; gi++) begin : g_lane
         ds_lane_class u_class (
            .kind   (in_kind[gi*KIND_W +: KIND_W]),
            .uops   (uops[gi*UOP_W +: UOP_W]),
            .single (single[gi]),
            .mcode  (mcode[gi])
         );
         assign uops_next[gi*UOP_W +: UOP_W] = acc[gi] ? uops[gi*UOP_W +: UOP_W] : '0;
      end
   endgenerate

   ds_group_pick #(.NUM_SLOTS(NUM_SLOTS)) u_pick (
      .ready  (in_ready),
      .valid  (in_valid),
      .single (single),
      .mcode  (mcode),
      .acc    (acc),
      .take   (in_take)
   );

   ds_mc_hold #(.CNT_W(CNT_W)) u_hold (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (acc[0] & mcode[0]),
      .cycles (in_mc_cycles),
      .ready  (in_ready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         out_valid <= 1'b0;
         out_fill  <= '0;
         out_uops  <= '0;
         out_mc    <= 1'b0;
      end else begin
         out_valid <= acc[0];
         out_fill  <= acc;
         out_uops  <= uops_next;
         out_mc    <= acc[0] & mcode[0];
      end
   end

   assert_slot0_first_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (out_fill != '0) |-> out_fill[0]);

   assert_mc_alone_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (out_valid && out_mc) |-> (out_fill == NUM_SLOTS'(1)));

   assert_idle_empty_R9: assert property (@(posedge clk) disable iff (!rst_n)
      !out_valid |-> (out_fill == '0 && !out_mc));

   generate
      for (gi = 1; gi < NUM_SLOTS; gi++) begin : g_chk
         assert_simple_tail_R4: assert property (@(posedge clk) disable iff (!rst_n)
            out_fill[gi] |-> (out_uops[gi*UOP_W +: UOP_W] == 3'd1));
      end
   endgenerate

endmodule

// File: tb/decode_steer_bench.sv
module decode_steer_bench;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [2:0] in_valid = '0;
   logic [8:0] in_kind = '0;
   logic [5:0] in_mc_cycles = '0;
   logic       in_ready;
   logic [1:0] in_take;
   logic       out_valid;
   logic [2:0] out_fill;
   logic [8:0] out_uops;
   logic       out_mc;

   int total = 0;
   int bad = 0;

   always #4 clk = ~clk;

   decode_steer u_decode_steer (
      .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
      .in_mc_cycles(in_mc_cycles), .in_ready(in_ready), .in_take(in_take),
      .out_valid(out_valid), .out_fill(out_fill), .out_uops(out_uops),
      .out_mc(out_mc)
   );

   task automatic check(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic present(input logic [2:0] v, input logic [2:0] k0,
                          input logic [2:0] k1, input logic [2:0] k2,
                          input logic [5:0] n);
      @(negedge clk);
      in_valid     = v;
      in_kind      = {k2, k1, k0};
      in_mc_cycles = n;
      #1;
   endtask

   task automatic idle();
      @(negedge clk);
      in_valid = '0;
   endtask

   // group check: take now, outputs after the edge
   task automatic group(input string req, input logic [2:0] v,
                        input logic [2:0] k0, input logic [2:0] k1,
                        input logic [2:0] k2, input int take_exp,
                        input int fill_exp, input int uops_exp, input int mc_exp);
      present(v, k0, k1, k2, 6'd0);
      check({req, " take"}, int'(in_take), take_exp);
      @(posedge clk); #1;
      check({req, " valid"}, int'(out_valid), (take_exp != 0) ? 1 : 0);
      check({req, " fill"}, int'(out_fill), fill_exp);
      check({req, " uops"}, int'(out_uops), uops_exp);
      check({req, " mc"}, int'(out_mc), mc_exp);
      idle();
   endtask

   task automatic t_reset();
      #1;
      check("R1 ready in reset", int'(in_ready), 0);
      in_valid = 3'b111;
      @(posedge clk); #1;
      check("R1 ready in reset", int'(in_ready), 0);
      @(negedge clk);
      rst_n = 1'b1;
      in_valid = '0;
      #1;
      check("R1 out_valid", int'(out_valid), 0);
      check("R1 out_fill", int'(out_fill), 0);
      check("R1 out_mc", int'(out_mc), 0);
      check("R1 ready after reset", int'(in_ready), 1);
   endtask

   task automatic t_best_groups();
      // R2 R3: read-modify (2) + reg-reg + load
      group("R3 rdmod+rr+ld", 3'b111, 3'd3, 3'd0, 3'd1, 3, 3'b111,
            {3'd1, 3'd1, 3'd2}, 0);
      // R2: read-modify-write (4) leader
      group("R2 rmw lead", 3'b111, 3'd5, 3'd1, 3'd0, 3, 3'b111,
            {3'd1, 3'd1, 3'd4}, 0);
      // R2: store leader, single lane
      group("R2 store alone", 3'b001, 3'd2, 3'd0, 3'd0, 1, 3'b001,
            {3'd0, 3'd0, 3'd2}, 0);
   endtask

   task automatic t_tail_stop();
      // R4: store in lane 2 stops the group after two
      group("R4 rr+rr+st", 3'b111, 3'd0, 3'd0, 3'd2, 2, 3'b011,
            {3'd0, 3'd1, 3'd1}, 0);
      // R5: reg-mem leader (3), store in lane 1, load in lane 2 not taken
      group("R5 regmem+st+ld", 3'b111, 3'd4, 3'd2, 3'd1, 1, 3'b001,
            {3'd0, 3'd0, 3'd3}, 0);
      // R5: invalid lane 1 stops lane 2
      group("R5 gap", 3'b101, 3'd0, 3'd0, 3'd0, 1, 3'b001,
            {3'd0, 3'd0, 3'd1}, 0);
   endtask

   task automatic t_slot0_first();
      // R6 R9: lane 0 empty, simple lanes behind it
      group("R6 no lead", 3'b110, 3'd0, 3'd0, 3'd1, 0, 3'b000, 0, 0);
   endtask

   task automatic t_mc_lane1();
      // R10: microcoded in lane 1 not taken
      group("R10 mc lane1", 3'b111, 3'd0, 3'd6, 3'd0, 1, 3'b001,
            {3'd0, 3'd0, 3'd1}, 0);
      group("R10 mc lane2", 3'b111, 3'd1, 3'd0, 3'd7, 2, 3'b011,
            {3'd0, 3'd1, 3'd1}, 0);
   endtask

   task automatic t_mc(input logic [5:0] n, input int low_exp);
      int low;
      present(3'b111, 3'd6, 3'd0, 3'd0, n);
      check("R7 mc take", int'(in_take), 1);
      @(posedge clk); #1;
      check("R7 mc fill", int'(out_fill), 1);
      check("R7 mc flag", int'(out_mc), 1);
      check("R7 mc uops", int'(out_uops), 0);
      low = 0;
      // keep offering simple work; nothing may be taken while held
      while (!in_ready && low < 100) begin
         check("R8 take while held", int'(in_take), 0);
         low++;
         @(posedge clk); #1;
      end
      check("R8 hold cycles", low, low_exp);
      in_valid = '0;
      @(posedge clk); #1;
      check("R9 idle after hold", int'(out_valid), 0);
      idle();
   endtask

   initial begin
      fork
         begin
            t_reset();
            t_best_groups();
            t_tail_stop();
            t_slot0_first();
            t_mc_lane1();
            t_mc(6'd4, 3);
            t_mc(6'd0, 1);
            t_mc(6'd2, 1);
         end
         begin
            repeat (5000) @(posedge clk);
            bad++;
            total++;
            $display("FAIL watchdog actual=1 expected=0");
         end
      join_any
      disable fork;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

endmodule